// File: doc/BRIEF.md
# Accumulator ALU (4-bit)

This block is a small arithmetic and logic unit whose only storage is one accumulator register. On every rising edge of the clock, a 3-bit opcode picks one of eight operations. The operation takes the present accumulator contents as its first operand and, where it needs one, an auxiliary input word as its second. The result is then written back into the accumulator. The accumulator is always visible on the output bus, so a host sees the effect of each operation one clock later.

The accumulator is the block's only state. It has two transitions. The first is *capture*: on a rising clock edge with the clear released, the accumulator takes the combinational result. The second is *clear*: at any time the active-low clear is low, the accumulator is forced to zero. There is no enable input, so every clock edge performs an operation. A host keeps the value unchanged by rotating it back into place or by reloading it.

Top module: `accalu`

## Requirements
- R1: While `clr_n` is low, `acc_out` is 0 immediately, without waiting for a clock edge, and it stays 0 across rising clock edges whatever the opcode.
- R2: Opcode 3'b000 (load) makes `acc_out` equal to `aux_in` after the next rising edge.
- R3: Opcode 3'b001 (add) makes `acc_out` equal to (acc + aux) mod 2^DATA_W after the next rising edge, and the carry is discarded.
- R4: Opcode 3'b010 (subtract) makes `acc_out` equal to (acc − aux) mod 2^DATA_W after the next rising edge, and the borrow is discarded.
- R5: Opcodes 3'b011, 3'b100 and 3'b101 make `acc_out` the bitwise AND, OR and XOR, respectively, of acc and aux after the next rising edge.
- R6: Opcode 3'b110 rotates acc right by one place, with bit 0 entering bit DATA_W−1. `aux_in` has no effect on the result.
- R7: Opcode 3'b111 rotates acc left by one place, with bit DATA_W−1 entering bit 0. `aux_in` has no effect on the result.
- R8: With `clr_n` high, `acc_out` changes only at a rising clock edge. A change to `opcode` or `aux_in` between edges leaves it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock; the accumulator captures on the rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the accumulator |
| opcode | input | 3 | Operation select |
| aux_in | input | DATA_W | Second operand word |
| acc_out | output | DATA_W | Present accumulator contents |

## Verification
A clear and a capture can meet in the same cycle: an operation is presented on `opcode` and `aux_in` while `clr_n` falls in the middle of the cycle and is held low across the next rising edge. The bench provokes this by lowering the clear during an add after a non-zero value has been loaded. It judges the result by reading zero just after the clear falls, before the edge, and again just after the edge. Once the clear is released, the next edge must apply the pending add to zero rather than to the value that was loaded before the clear.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD = 3'b000,
        OP_ADD  = 3'b001,
        OP_SUB  = 3'b010,
        OP_AND  = 3'b011,
        OP_OR   = 3'b100,
        OP_XOR  = 3'b101,
        OP_ROR  = 3'b110,
        OP_ROL  = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } lg_e;

    // control word handed from the decoder to the datapath
    typedef struct packed {
        logic take_aux;
        logic arith;
        logic subtract;
        logic logic_op;
        lg_e  lsel;
        logic rot_left;
    } ctl_t;

endpackage

// File: rtl/accalu_decode.sv
module accalu_decode
    import accalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctl_t             ctl
);

    always_comb begin
        ctl = '{take_aux: 1'b0, arith: 1'b0, subtract: 1'b0,
                logic_op: 1'b0, lsel: LG_AND, rot_left: 1'b0};
        unique case (op_e'(opcode))
            OP_LOAD: ctl.take_aux = 1'b1;
            OP_ADD:  ctl.arith    = 1'b1;
            OP_SUB: begin
                ctl.arith    = 1'b1;
                ctl.subtract = 1'b1;
            end
            OP_AND: begin
                ctl.logic_op = 1'b1;
                ctl.lsel     = LG_AND;
            end
            OP_OR: begin
                ctl.logic_op = 1'b1;
                ctl.lsel     = LG_OR;
            end
            OP_XOR: begin
                ctl.logic_op = 1'b1;
                ctl.lsel     = LG_XOR;
            end
            OP_ROR:  ctl.rot_left = 1'b0;
            OP_ROL:  ctl.rot_left = 1'b1;
        endcase
    end

endmodule

// File: rtl/accalu_datapath.sv
module accalu_datapath
    import accalu_pkg::*;
#(
    parameter int W = 4
) (
    input  ctl_t         ctl,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] aux,
    output logic [W-1:0] result
);

    logic [W-1:0] opnd_b;
    logic [W-1:0] sum;
    logic [W-1:0] lres;
    logic [W-1:0] ror_v;
    logic [W-1:0] rol_v;

    // subtract as acc + ~aux + 1, wrapping at W bits
    assign opnd_b = ctl.subtract ? ~aux : aux;
    assign sum    = acc + opnd_b + W'(ctl.subtract);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (ctl.lsel)
                LG_OR:   lres[i] = acc[i] | aux[i];
                LG_XOR:  lres[i] = acc[i] ^ aux[i];
                default: lres[i] = acc[i] & aux[i];
            endcase
        end
        assign ror_v[i] = acc[(i + 1) % W];
        assign rol_v[i] = acc[(i + W - 1) % W];
    end

    always_comb begin
        if (ctl.take_aux)
            result = aux;
        else if (ctl.arith)
            result = sum;
        else if (ctl.logic_op)
            result = lres;
        else if (ctl.rot_left)
            result = rol_v;
        else
            result = ror_v;
    end

endmodule

// File: rtl/accalu_acc.sv
module accalu_acc #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/accalu.sv
module accalu
    import accalu_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] aux_in,
    output logic [DATA_W-1:0] acc_out
);

    ctl_t              ctl;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] alu_res;

    accalu_decode u_dec (
        .opcode (opcode),
        .ctl    (ctl)
    );

    accalu_datapath #(.W(DATA_W)) u_dp (
        .ctl    (ctl),
        .acc    (acc_q),
        .aux    (aux_in),
        .result (alu_res)
    );

    accalu_acc #(.W(DATA_W)) u_acc (
        .clk    (clk),
        .clr_n  (clr_n),
        .d      (alu_res),
        .q      (acc_q)
    );

    assign acc_out = acc_q;

endmodule

// File: rtl/accalu_checker.sv
module accalu_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic [2:0]   opcode,
    input logic [W-1:0] aux_in,
    input logic [W-1:0] acc_out
);

    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> acc_out == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b000 |=> acc_out == $past(aux_in));

    assert_add_R3: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b001 |=> acc_out == W'($past(acc_out) + $past(aux_in)));

    assert_sub_R4: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b010 |=> acc_out == W'($past(acc_out) - $past(aux_in)));

    assert_and_R5: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b011 |=> acc_out == ($past(acc_out) & $past(aux_in)));

    assert_or_R5: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b100 |=> acc_out == ($past(acc_out) | $past(aux_in)));

    assert_xor_R5: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b101 |=> acc_out == ($past(acc_out) ^ $past(aux_in)));

    assert_ror_R6: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b110 |=> acc_out == {$past(acc_out[0]), $past(acc_out[W-1:1])});

    assert_ror_ones_R6: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b110 |=> $countones(acc_out) == $countones($past(acc_out)));

    assert_rol_R7: assert property (@(posedge clk) disable iff (!clr_n)
        opcode == 3'b111 |=> acc_out == {$past(acc_out[W-2:0]), $past(acc_out[W-1])});

endmodule

bind accalu accalu_checker #(.W(DATA_W)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .opcode  (opcode),
    .aux_in  (aux_in),
    .acc_out (acc_out)
);

// File: tb/accalu_bench.sv
module accalu_bench;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic [2:0]   opcode = 3'b000;
    logic [W-1:0] aux_in = '0;
    logic [W-1:0] acc_out;

    int total = 0;
    int bad   = 0;

    accalu #(.DATA_W(W)) u_accalu (
        .clk     (clk),
        .clr_n   (clr_n),
        .opcode  (opcode),
        .aux_in  (aux_in),
        .acc_out (acc_out)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] model(input logic [2:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        int s;
        case (op)
            3'b000: return b;
            3'b001: begin s = (int'(a) + int'(b)) % N; return W'(s); end
            3'b010: begin s = (int'(a) - int'(b) + N) % N; return W'(s); end
            3'b011: return a & b;
            3'b100: return a | b;
            3'b101: return a ^ b;
            3'b110: return W'((int'(a) >> 1) | ((int'(a) & 1) << (W - 1)));
            default: return W'(((int'(a) << 1) | (int'(a) >> (W - 1))) % N);
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: acc_out=%h expected=%h", req, got, exp);
        end
    endtask

    // one rising edge, then back to the falling edge for sampling and driving
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic [2:0] op, input logic [W-1:0] b);
        opcode = op;
        aux_in = b;
        step();
    endtask

    task automatic t_reset();
        #5 clr_n = 1'b0;
        #1 check("R1", acc_out, '0);
        opcode = 3'b000;
        aux_in = 4'hF;
        step();
        step();
        check("R1", acc_out, '0);
        clr_n = 1'b1;
    endtask

    task automatic t_load();
        for (int v = 0; v < N; v++) begin
            apply(3'b000, W'(v));
            check("R2", acc_out, W'(v));
        end
    endtask

    task automatic t_binary(input logic [2:0] op, input string req);
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                apply(3'b000, W'(a));
                apply(op, W'(b));
                check(req, acc_out, model(op, W'(a), W'(b)));
            end
        end
    endtask

    task automatic t_rotate(input logic [2:0] op, input string req);
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                apply(3'b000, W'(a));
                apply(op, W'(b));
                check(req, acc_out, model(op, W'(a), '0));
            end
        end
        // a full lap of rotations restores the start value
        apply(3'b000, W'(1));
        for (int k = 0; k < W; k++) begin
            apply(op, W'(k));
            check(req, acc_out, model(op, W'(1 << ((op == 3'b111) ? k : (W - k) % W)), '0));
        end
        check(req, acc_out, W'(1));
    endtask

    task automatic t_hold();
        apply(3'b000, W'(5));
        opcode = 3'b001;
        aux_in = W'(1);
        #3 check("R8", acc_out, W'(5));
        aux_in = W'(2);
        #3 check("R8", acc_out, W'(5));
        step();
        check("R8", acc_out, W'(7));
    endtask

    task automatic t_clear_clash();
        apply(3'b000, W'(9));
        opcode = 3'b001;
        aux_in = W'(3);
        #3 clr_n = 1'b0;
        #1 check("R1", acc_out, '0);
        @(posedge clk);
        #2 check("R1", acc_out, '0);
        @(negedge clk);
        clr_n = 1'b1;
        step();
        check("R3", acc_out, W'(3));
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: acc_out=%h expected=finish", acc_out);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_binary(3'b001, "R3");
        t_binary(3'b010, "R4");
        t_binary(3'b011, "R5");
        t_binary(3'b100, "R5");
        t_binary(3'b101, "R5");
        t_rotate(3'b110, "R6");
        t_rotate(3'b111, "R7");
        t_hold();
        t_clear_clash();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule